// File: doc/BRIEF.md
# Message-Signaled Interrupt Aggregator

The block gathers a set of level-sensitive interrupt lines from a bus bridge and turns new assertions into message writes to the processor. For every line it keeps a pending bit, which records that the line went high, and a level bit, which follows the present state of the line. Software reads and clears these bits through a small word-addressed register port. It also programs a per-line enable mask, a per-line route bit and two message target registers.

When a line rises and is enabled, the block builds one 32-bit memory write from the chosen target register. The address is the target value with its low five bits forced to zero. The data is those five low bits, zero-extended. Writes leave on a single-beat valid/ready master port. A short queue absorbs deliveries that arrive while the port is stalled, and a sticky flag records any delivery lost because the queue was full.

Top module: `msi_irq_aggregator`

## Requirements
- R1: The level bit of each line equals the state of the line at the previous clock edge. It is set on a rise and cleared on a fall, and reads as register word offset 3.
- R2: A pending bit is set only when its line goes from 0 to 1. A line that stays high does not set it again or start another delivery.
- R3: A read of the pending register (offset 2) returns the current value and clears it at that clock edge. A write of any value to offset 2 also clears it. A rise in the same cycle as a clear leaves its bit set.
- R4: In a cycle where at least one line rises with its mask bit (offset 0) set to 1, exactly one write is queued, visible on the master port one edge later. Rises on lines whose mask bit is 0 queue nothing.
- R5: The write uses target 1 (offset 7) if any enabled rising line in that cycle has its route bit (offset 1) at 1. Otherwise it uses target 0 (offset 6).
- R6: The write address is the selected target with bits 4:0 cleared. The write data is bits 4:0 of the target, zero-extended to 32 bits.
- R7: Offset 4 reads level AND mask AND NOT route. Offset 5 reads level AND mask AND route.
- R8: After reset, both targets read 0xFFFB0003. Mask, route, pending, level and the overflow flag read 0, and no write is offered.
- R9: While a write is offered and ready is low, valid stays high and the address and data stay unchanged. Queued writes leave in the order they were triggered, one per cycle in which valid and ready are both high.
- R10: Up to 4 writes can wait. A delivery triggered while 4 are waiting and none leaves in that cycle is dropped, and bit 0 of the status register (offset 8) becomes 1 and stays 1 until reset.
- R11: Read data is combinational while the read strobe is high and is zero otherwise. Writes to the read-only offsets 3, 4, 5 and 8 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 11 | Level interrupt lines |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| mw_valid | output | 1 | Message write offered |
| mw_ready | input | 1 | Message write accepted |
| mw_addr | output | 32 | Message write address |
| mw_data | output | 32 | Message write data |

## Verification
A line change that is applied before a rising edge shows up after that same edge in the level and pending registers and on the master port's valid, address and data, so each result is due one edge after its stimulus. Register read data is combinational and is due in the cycle of the read. The pending clear and each queue pop take effect at the edge where the read strobe, or valid together with ready, is high. The bench drives inputs on the falling edge and samples results at the next falling edge, which places every check exactly one rising edge after its cause. Multi-cycle behaviour such as stall holding, queue depth and overflow is checked by counting falling edges.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
   localparam int unsigned REG_AW = 4;
   localparam logic [31:0] TGT_RESET = 32'hFFFB_0003;

   typedef enum logic [REG_AW-1:0] {
      OFF_MASK  = 4'd0,
      OFF_ROUTE = 4'd1,
      OFF_PEND  = 4'd2,
      OFF_LEVEL = 4'd3,
      OFF_VIEW0 = 4'd4,
      OFF_VIEW1 = 4'd5,
      OFF_TGT0  = 4'd6,
      OFF_TGT1  = 4'd7,
      OFF_STAT  = 4'd8
   } reg_off_e;
endpackage

// File: rtl/msi_line_edge.sv
module msi_line_edge #(
   parameter int unsigned N = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] line_in,
   output logic [N-1:0] level,
   output logic [N-1:0] rise
);
   for (genvar i = 0; i < N; i++) begin : g_line
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= line_in[i];
      end
      assign level[i] = q;
      assign rise[i]  = line_in[i] & ~q;
   end
endmodule

// File: rtl/msi_ctrl_regs.sv
module msi_ctrl_regs
   import msi_agg_pkg::*;
#(
   parameter int unsigned N  = 11,
   parameter int unsigned DW = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [REG_AW-1:0] addr,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rdata,
   input  logic [N-1:0]      rise,
   input  logic [N-1:0]      level,
   input  logic              ovf_set,
   output logic [N-1:0]      mask,
   output logic [N-1:0]      route,
   output logic [N-1:0]      pend,
   output logic [DW-1:0]     tgt0,
   output logic [DW-1:0]     tgt1,
   output logic              ovf
);
   localparam int unsigned PADW = DW - N;

   reg_off_e   off;
   logic       pend_clr;
   logic [N-1:0] view0, view1;

   assign off      = reg_off_e'(addr);
   assign pend_clr = (wr_en || rd_en) && (off == OFF_PEND);
   assign view0    = level & mask & ~route;
   assign view1    = level & mask & route;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask  <= '0;
         route <= '0;
         tgt0  <= DW'(TGT_RESET);
         tgt1  <= DW'(TGT_RESET);
      end else if (wr_en) begin
         case (off)
            OFF_MASK:  mask  <= wdata[N-1:0];
            OFF_ROUTE: route <= wdata[N-1:0];
            OFF_TGT0:  tgt0  <= wdata;
            OFF_TGT1:  tgt1  <= wdata;
            default: ;
         endcase
      end
   end

   // new rises win over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend_clr ? '0 : pend) | rise;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovf <= 1'b0;
      else if (ovf_set) ovf <= 1'b1;
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (off)
            OFF_MASK:  rdata = {{PADW{1'b0}}, mask};
            OFF_ROUTE: rdata = {{PADW{1'b0}}, route};
            OFF_PEND:  rdata = {{PADW{1'b0}}, pend};
            OFF_LEVEL: rdata = {{PADW{1'b0}}, level};
            OFF_VIEW0: rdata = {{PADW{1'b0}}, view0};
            OFF_VIEW1: rdata = {{PADW{1'b0}}, view1};
            OFF_TGT0:  rdata = tgt0;
            OFF_TGT1:  rdata = tgt1;
            OFF_STAT:  rdata = {{(DW-1){1'b0}}, ovf};
            default:   rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/msi_msg_fifo.sv
module msi_msg_fifo #(
   parameter int unsigned W     = 32,
   parameter int unsigned DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [CW-1:0] cnt;

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == LAST) ? '0 : p + 1'b1;
   endfunction

   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));
   assign dout  = mem[rp];

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= bump(wp);
         if (pop)  rp <= bump(rp);
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/msi_irq_aggregator.sv
module msi_irq_aggregator
   import msi_agg_pkg::*;
#(
   parameter int unsigned NUM_LINES  = 11,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LOW_BITS   = 5,
   parameter int unsigned FIFO_DEPTH = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic                 reg_wr_en,
   input  logic                 reg_rd_en,
   input  logic [REG_AW-1:0]    reg_addr,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   output logic                 mw_valid,
   input  logic                 mw_ready,
   output logic [ADDR_W-1:0]    mw_addr,
   output logic [DATA_W-1:0]    mw_data
);
   if (NUM_LINES < 1 || NUM_LINES >= DATA_W) begin : g_bad_lines
      $error("NUM_LINES must be in 1..DATA_W-1");
   end
   if (ADDR_W != DATA_W) begin : g_bad_width
      $error("target register must hold a full address");
   end
   if (LOW_BITS < 1 || LOW_BITS >= ADDR_W) begin : g_bad_low
      $error("LOW_BITS out of range");
   end
   if (FIFO_DEPTH < 1) begin : g_bad_depth
      $error("FIFO_DEPTH must be at least 1");
   end

   logic [NUM_LINES-1:0] level_q, rise, mask_q, route_q, pend_q;
   logic [DATA_W-1:0]    tgt0_q, tgt1_q, sel_tgt, head;
   logic                 ovf_q, ovf_set, fire, route_hit;
   logic                 push_ok, pop, q_empty, q_full;

   msi_line_edge #(.N(NUM_LINES)) u_edge (
      .clk(clk), .rst_n(rst_n), .line_in(irq_in),
      .level(level_q), .rise(rise)
   );

   msi_ctrl_regs #(.N(NUM_LINES), .DW(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr_en), .rd_en(reg_rd_en), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata),
      .rise(rise), .level(level_q), .ovf_set(ovf_set),
      .mask(mask_q), .route(route_q), .pend(pend_q),
      .tgt0(tgt0_q), .tgt1(tgt1_q), .ovf(ovf_q)
   );

   assign fire      = |(rise & mask_q);
   assign route_hit = |(rise & mask_q & route_q);
   assign sel_tgt   = route_hit ? tgt1_q : tgt0_q;

   assign pop     = mw_valid && mw_ready;
   assign push_ok = fire && (!q_full || pop);
   assign ovf_set = fire && q_full && !pop;

   msi_msg_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push_ok), .pop(pop),
      .din(sel_tgt), .dout(head), .empty(q_empty), .full(q_full)
   );

   assign mw_valid = !q_empty;
   assign mw_addr  = {head[ADDR_W-1:LOW_BITS], {LOW_BITS{1'b0}}};
   assign mw_data  = {{(DATA_W-LOW_BITS){1'b0}}, head[LOW_BITS-1:0]};
endmodule

// File: rtl/msi_irq_aggregator_chk.sv
module msi_irq_aggregator_chk
   import msi_agg_pkg::*;
#(
   parameter int unsigned NUM_LINES = 11,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned LOW_BITS  = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] irq_in,
   input logic [NUM_LINES-1:0] level,
   input logic [NUM_LINES-1:0] mask,
   input logic [NUM_LINES-1:0] pending,
   input logic                 ovf,
   input logic                 reg_rd_en,
   input logic [REG_AW-1:0]    reg_addr,
   input logic                 mw_valid,
   input logic                 mw_ready,
   input logic [ADDR_W-1:0]    mw_addr,
   input logic [DATA_W-1:0]    mw_data
);
   assert_level_tracks_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> level == $past(irq_in));

   assert_pend_read_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_en && reg_addr == OFF_PEND && (irq_in & ~level) == '0) |=> pending == '0);

   assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!mw_valid && ((irq_in & ~level) & mask) == '0) |=> !mw_valid);

   assert_msg_format_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mw_valid |-> (mw_addr[LOW_BITS-1:0] == '0 && mw_data[DATA_W-1:LOW_BITS] == '0));

   assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data)));

   assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
endmodule

bind msi_irq_aggregator msi_irq_aggregator_chk #(
   .NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LOW_BITS(LOW_BITS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level(level_q),
   .mask(mask_q), .pending(pend_q), .ovf(ovf_q),
   .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
   .mw_valid(mw_valid), .mw_ready(mw_ready),
   .mw_addr(mw_addr), .mw_data(mw_data)
);

// File: tb/msi_irq_aggregator_test.sv
`timescale 1ns/1ps
module msi_irq_aggregator_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] irq_in = '0;
   logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mw_valid, mw_ready = 1'b0;
   logic [31:0] mw_addr, mw_data;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   localparam logic [3:0] A_MASK = 4'd0, A_ROUTE = 4'd1, A_PEND = 4'd2, A_LEVEL = 4'd3,
                          A_V0 = 4'd4, A_V1 = 4'd5, A_T0 = 4'd6, A_T1 = 4'd7, A_STAT = 4'd8;
   localparam logic [31:0] T0 = 32'h1234_5687, T1 = 32'hABCD_E01F;

   // {mask, route, irq, expect_write, expect_target1}
   localparam int NV = 8;
   localparam logic [34:0] VEC [NV] = '{
      {11'h001, 11'h000, 11'h001, 1'b1, 1'b0},
      {11'h001, 11'h001, 11'h001, 1'b1, 1'b1},
      {11'h000, 11'h000, 11'h7FF, 1'b0, 1'b0},
      {11'h400, 11'h400, 11'h400, 1'b1, 1'b1},
      {11'h00F, 11'h004, 11'h003, 1'b1, 1'b0},
      {11'h00F, 11'h004, 11'h006, 1'b1, 1'b1},
      {11'h0F0, 11'h000, 11'h00F, 1'b0, 1'b0},
      {11'h7FF, 11'h000, 11'h7FF, 1'b1, 1'b0}
   };

   msi_irq_aggregator uut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mw_valid(mw_valid), .mw_ready(mw_ready),
      .mw_addr(mw_addr), .mw_data(mw_data)
   );

   always #4 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a; reg_rd_en = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd_en = 1'b0;
   endtask

   task automatic chk_msg(input string req, input logic [31:0] tgt);
      chk(req, {31'd0, mw_valid}, 32'd1);
      chk(req, mw_addr, tgt & 32'hFFFF_FFE0);
      chk(req, mw_data, tgt & 32'h0000_001F);
   endtask

   task automatic pop_one();
      mw_ready = 1'b1;
      @(negedge clk);
      mw_ready = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #800000;
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R8 reset state, R11 strobe-gated read data
      chk("R8 no write", {31'd0, mw_valid}, 32'd0);
      rd(A_T0, v);   chk("R8 tgt0", v, 32'hFFFB_0003);
      rd(A_T1, v);   chk("R8 tgt1", v, 32'hFFFB_0003);
      rd(A_MASK, v); chk("R8 mask", v, 32'd0);
      rd(A_ROUTE, v); chk("R8 route", v, 32'd0);
      rd(A_PEND, v); chk("R8 pend", v, 32'd0);
      rd(A_LEVEL, v); chk("R8 level", v, 32'd0);
      rd(A_STAT, v); chk("R8 stat", v, 32'd0);
      #1 chk("R11 idle rdata", reg_rdata, 32'd0);

      // R8 default target drives message
      wr(A_MASK, 32'h1);
      irq_in = 11'h001;
      @(negedge clk);
      chk_msg("R8 R6 default target", 32'hFFFB_0003);
      pop_one();
      irq_in = '0;
      @(negedge clk);
      rd(A_PEND, v);

      wr(A_T0, T0);
      wr(A_T1, T1);
      rd(A_T0, v); chk("R11 tgt0 readback", v, T0);

      // vector table
      for (int i = 0; i < NV; i++) begin
         logic [10:0] m, r, q;
         logic ew, es;
         {m, r, q, ew, es} = VEC[i];
         wr(A_MASK, {21'd0, m});
         wr(A_ROUTE, {21'd0, r});
         irq_in = q;
         @(negedge clk);
         chk($sformatf("R4 vec%0d valid", i), {31'd0, mw_valid}, {31'd0, ew});
         if (ew) chk_msg($sformatf("R5 R6 vec%0d", i), es ? T1 : T0);
         rd(A_LEVEL, v); chk($sformatf("R1 vec%0d level", i), v, {21'd0, q});
         rd(A_V0, v);    chk($sformatf("R7 vec%0d view0", i), v, {21'd0, q & m & ~r});
         rd(A_V1, v);    chk($sformatf("R7 vec%0d view1", i), v, {21'd0, q & m & r});
         rd(A_PEND, v);  chk($sformatf("R2 vec%0d pend", i), v, {21'd0, q});
         rd(A_PEND, v);  chk($sformatf("R3 vec%0d cleared", i), v, 32'd0);
         pop_one();
         chk($sformatf("R2 vec%0d held high no retrigger", i), {31'd0, mw_valid}, 32'd0);
         irq_in = '0;
         @(negedge clk);
         rd(A_LEVEL, v); chk($sformatf("R1 vec%0d fall", i), v, 32'd0);
         rd(A_PEND, v);  chk($sformatf("R2 vec%0d fall no pend", i), v, 32'd0);
      end

      // R3 write clears pending
      wr(A_MASK, 32'd0);
      irq_in = 11'h020;
      @(negedge clk);
      wr(A_PEND, 32'h7FF);
      rd(A_PEND, v); chk("R3 write clears", v, 32'd0);
      irq_in = '0;
      @(negedge clk);

      // R3 rise in same cycle as clear is kept
      irq_in = 11'h008;
      wr(A_PEND, 32'd0);
      rd(A_PEND, v); chk("R3 rise beats clear", v, 32'h008);
      irq_in = '0;
      @(negedge clk);

      // R11 read-only offsets ignore writes
      wr(A_LEVEL, 32'h7FF);
      wr(A_STAT, 32'h1);
      rd(A_LEVEL, v); chk("R11 level ro", v, 32'd0);
      rd(A_STAT, v);  chk("R11 stat ro", v, 32'd0);

      // R9 stall hold and order
      wr(A_MASK, 32'h3);
      wr(A_ROUTE, 32'h2);
      irq_in = 11'h001;
      @(negedge clk);
      irq_in = 11'h000;
      @(negedge clk);
      irq_in = 11'h002;
      @(negedge clk);
      irq_in = 11'h000;
      repeat (3) @(negedge clk);
      chk_msg("R9 first held", T0);
      pop_one();
      chk_msg("R9 second in order", T1);
      pop_one();
      chk("R9 drained", {31'd0, mw_valid}, 32'd0);

      // R10 overflow
      for (int k = 0; k < 6; k++) begin
         irq_in = 11'h001;
         @(negedge clk);
         irq_in = 11'h000;
         @(negedge clk);
      end
      rd(A_STAT, v); chk("R10 overflow flag", v, 32'd1);
      begin
         int n = 0;
         mw_ready = 1'b1;
         for (int k = 0; k < 10; k++) begin
            if (mw_valid) n++;
            @(negedge clk);
         end
         mw_ready = 1'b0;
         chk("R10 only depth kept", n, 32'd4);
      end
      rd(A_STAT, v); chk("R10 flag sticky", v, 32'd1);

      finish_run();
   end
endmodule